// File: doc/BRIEF.md
# Test Access Port Controller

This block is the sixteen-state sequencer at the heart of a boundary-scan test port. A single steering input, sampled on each rising edge of the test clock, walks it through a reset state, an idle state and two mirrored branches. One branch serves the data registers and the other serves the instruction register. Each branch has a select, capture, shift, first exit, pause, second exit and update state. The pause and exit states let a long shift be halted and then resumed without losing position.

From the current state the block decodes the strobes that the surrounding register logic needs. Capture and shift strobes are plain decodes of the state, and the register logic acts on them at the next rising edge. The update strobes and the serial-output enable are re-timed on the falling edge, so they change half a cycle into their state. A select output tells the output multiplexer which branch owns the serial path. A level output marks the test-logic reset state. An active-low asynchronous reset input forces the reset state at any time.

The state code is brought out for observation. Its encoding is fixed: reset 0, idle 1, data branch 2 to 8, instruction branch 9 to 15. Within each branch the order is select, capture, shift, exit1, pause, exit2, update.

Top module: `tap_ctrl`

## Requirements
- R1: While `trst_n` is low, `state_o` is 0 at once, without waiting for a clock edge, and `tdo_en_o`, `upd_dr_o` and `upd_ir_o` are 0.
- R2: On each rising `tck` edge the state moves as follows (codes: reset 0, idle 1, data select 2, capture 3, shift 4, exit1 5, pause 6, exit2 7, update 8; instruction select 9, capture 10, shift 11, exit1 12, pause 13, exit2 14, update 15). With `tms`=0: reset→idle, idle→idle, select→capture of its branch, capture→shift, shift→shift, exit1→pause, pause→pause, exit2→shift, update→idle. With `tms`=1: reset→reset, idle→2, 2→9, 9→0, capture→exit1, shift→exit1, exit1→update, pause→exit2, exit2→update, either update→2.
- R3: Five consecutive rising edges with `tms`=1 leave the controller in state 0, whatever state it started in.
- R4: `cap_dr_o`, `sh_dr_o`, `cap_ir_o` and `sh_ir_o` are high exactly while the state is 3, 4, 10 and 11 respectively.
- R5: `upd_dr_o` (`upd_ir_o`) rises on the falling `tck` edge that occurs while the state is 8 (15), and stays high until the next falling edge.
- R6: `tdo_en_o` rises on the falling edge that occurs while the state is 4 or 11, and stays high until the next falling edge.
- R7: `ir_sel_o` is high exactly while the state is 9 through 15.
- R8: `test_reset_o` is high exactly while the state is 0.
- R9: In a pause state with `tms`=0 the state holds and the shift strobe stays low. An exit2 with `tms`=0 returns to the same branch's shift state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous reset, active low |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| state_o | output | 4 | Current state code |
| test_reset_o | output | 1 | High in the test-logic reset state |
| ir_sel_o | output | 1 | High while the instruction branch owns the path |
| cap_dr_o | output | 1 | Data capture strobe |
| sh_dr_o | output | 1 | Data shift strobe |
| upd_dr_o | output | 1 | Data update strobe, falling-edge timed |
| cap_ir_o | output | 1 | Instruction capture strobe |
| sh_ir_o | output | 1 | Instruction shift strobe |
| upd_ir_o | output | 1 | Instruction update strobe, falling-edge timed |
| tdo_en_o | output | 1 | Serial output enable, falling-edge timed |

## Verification
The properties assume that `tms` is a known 0 or 1 at every rising edge. They also assume that `trst_n` is never released at the same instant as a clock edge. The bench therefore changes `tms` and `trst_n` only shortly after a falling edge, so they are settled half a cycle before the rising edge that samples them. The bench drives `tms` from a deterministic pseudo-random sequence and from fixed paths, and it never leaves `tms` undriven.

// File: rtl/tap_pkg.sv
package tap_pkg;
  localparam int STW     = 4;
  localparam int BR_LEN  = 7;
  localparam int DR_BASE = 2;
  localparam int IR_BASE = DR_BASE + BR_LEN;
  localparam int NBR     = 2;

  typedef logic [STW-1:0] tap_code_t;

  localparam tap_code_t S_RESET = tap_code_t'(0);
  localparam tap_code_t S_IDLE  = tap_code_t'(1);

  // offsets inside a branch
  localparam int K_SEL = 0;
  localparam int K_CAP = 1;
  localparam int K_SH  = 2;
  localparam int K_EX1 = 3;
  localparam int K_PAU = 4;
  localparam int K_EX2 = 5;
  localparam int K_UPD = 6;

  function automatic tap_code_t branch_code(input int base, input int k);
    return tap_code_t'(base + k);
  endfunction

  function automatic tap_code_t tap_step(input tap_code_t s, input logic t);
    int base;
    int k;
    tap_code_t n;
    n = S_RESET;
    if (s == S_RESET) begin
      n = t ? S_RESET : S_IDLE;
    end else if (s == S_IDLE) begin
      n = t ? branch_code(DR_BASE, K_SEL) : S_IDLE;
    end else begin
      base = (int'(s) >= IR_BASE) ? IR_BASE : DR_BASE;
      k    = int'(s) - base;
      case (k)
        K_SEL:   n = t ? ((base == DR_BASE) ? branch_code(IR_BASE, K_SEL) : S_RESET)
                       : branch_code(base, K_CAP);
        K_CAP:   n = branch_code(base, t ? K_EX1 : K_SH);
        K_SH:    n = branch_code(base, t ? K_EX1 : K_SH);
        K_EX1:   n = branch_code(base, t ? K_UPD : K_PAU);
        K_PAU:   n = branch_code(base, t ? K_EX2 : K_PAU);
        K_EX2:   n = branch_code(base, t ? K_UPD : K_SH);
        default: n = t ? branch_code(DR_BASE, K_SEL) : S_IDLE;
      endcase
    end
    return n;
  endfunction
endpackage

// File: rtl/tap_next.sv
module tap_next
  import tap_pkg::*;
(
  input  tap_code_t cur_i,
  input  logic      tms_i,
  output tap_code_t nxt_o
);
  always_comb nxt_o = tap_step(cur_i, tms_i);
endmodule

// File: rtl/tap_state_reg.sv
module tap_state_reg
  import tap_pkg::*;
(
  input  logic      tck,
  input  logic      trst_n,
  input  tap_code_t nxt_i,
  output tap_code_t cur_o
);
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) cur_o <= S_RESET;
    else         cur_o <= nxt_i;
  end
endmodule

// File: rtl/tap_fall_regs.sv
module tap_fall_regs #(
  parameter int N = 2
) (
  input  logic         tck,
  input  logic         trst_n,
  input  logic         shift_any_i,
  input  logic [N-1:0] upd_now_i,
  output logic         tdo_en_o,
  output logic [N-1:0] upd_o
);
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo_en_o <= 1'b0;
      upd_o    <= '0;
    end else begin
      tdo_en_o <= shift_any_i;
      upd_o    <= upd_now_i;
    end
  end
endmodule

// File: rtl/tap_ctrl.sv
module tap_ctrl
  import tap_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output logic [3:0] state_o,
  output logic       test_reset_o,
  output logic       ir_sel_o,
  output logic       cap_dr_o,
  output logic       sh_dr_o,
  output logic       upd_dr_o,
  output logic       cap_ir_o,
  output logic       sh_ir_o,
  output logic       upd_ir_o,
  output logic       tdo_en_o
);
  tap_code_t        cur, nxt;
  logic [NBR-1:0]   cap_v, sh_v, upd_now, upd_q;

  tap_next      u_next (.cur_i(cur), .tms_i(tms), .nxt_o(nxt));
  tap_state_reg u_sreg (.tck(tck), .trst_n(trst_n), .nxt_i(nxt), .cur_o(cur));

  for (genvar b = 0; b < NBR; b++) begin : g_br
    localparam int BASE = DR_BASE + b * BR_LEN;
    assign cap_v[b]   = (cur == branch_code(BASE, K_CAP));
    assign sh_v[b]    = (cur == branch_code(BASE, K_SH));
    assign upd_now[b] = (cur == branch_code(BASE, K_UPD));
  end

  tap_fall_regs #(.N(NBR)) u_fall (
    .tck(tck), .trst_n(trst_n), .shift_any_i(|sh_v),
    .upd_now_i(upd_now), .tdo_en_o(tdo_en_o), .upd_o(upd_q)
  );

  assign state_o      = cur;
  assign test_reset_o = (cur == S_RESET);
  assign ir_sel_o     = (cur >= branch_code(IR_BASE, K_SEL));
  assign cap_dr_o     = cap_v[0];
  assign sh_dr_o      = sh_v[0];
  assign upd_dr_o     = upd_q[0];
  assign cap_ir_o     = cap_v[1];
  assign sh_ir_o      = sh_v[1];
  assign upd_ir_o     = upd_q[1];
endmodule

// File: rtl/tap_ctrl_chk.sv
module tap_ctrl_chk (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic [3:0] state_o,
  input logic       sh_dr_o,
  input logic       sh_ir_o,
  input logic       upd_dr_o,
  input logic       upd_ir_o,
  input logic       tdo_en_o
);
  logic [2:0] ones;
  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)      ones <= '0;
    else if (!tms)    ones <= '0;
    else if (ones != 3'd7) ones <= ones + 3'd1;
  end

  // R2
  tms_known_chk: assert property (@(posedge tck) disable iff (!trst_n) !$isunknown(tms));
  // R2
  reset_leave_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == 4'd0 && !tms) |=> state_o == 4'd1);
  // R2
  irsel_escape_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == 4'd9 && tms) |=> state_o == 4'd0);
  // R3
  five_ones_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (ones >= 3'd5) |-> state_o == 4'd0);
  // R5
  upd_dr_align_chk: assert property (@(posedge tck) disable iff (!trst_n)
    upd_dr_o == (state_o == 4'd8));
  // R5
  upd_ir_align_chk: assert property (@(posedge tck) disable iff (!trst_n)
    upd_ir_o == (state_o == 4'd15));
  // R6
  tdo_en_align_chk: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_en_o == (state_o == 4'd4 || state_o == 4'd11));
  // R9
  pause_dr_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == 4'd6 && !tms) |=> (state_o == 4'd6 && !sh_dr_o));
  // R9
  pause_ir_hold_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == 4'd13 && !tms) |=> (state_o == 4'd13 && !sh_ir_o));
  // R9
  exit2_resume_chk: assert property (@(posedge tck) disable iff (!trst_n)
    (state_o == 4'd7 && !tms) |=> sh_dr_o);
endmodule

bind tap_ctrl tap_ctrl_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
  .sh_dr_o(sh_dr_o), .sh_ir_o(sh_ir_o), .upd_dr_o(upd_dr_o),
  .upd_ir_o(upd_ir_o), .tdo_en_o(tdo_en_o)
);

// File: tb/tap_ctrl_test.sv
module tap_ctrl_test;
  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic tms = 1'b1;
  logic [3:0] state_o;
  logic test_reset_o, ir_sel_o, cap_dr_o, sh_dr_o, upd_dr_o;
  logic cap_ir_o, sh_ir_o, upd_ir_o, tdo_en_o;

  int nchk = 0;
  int nfail = 0;
  int ms = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic [31:0] cov = '0;

  always #5 tck = ~tck;

  tap_ctrl uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state_o(state_o),
    .test_reset_o(test_reset_o), .ir_sel_o(ir_sel_o),
    .cap_dr_o(cap_dr_o), .sh_dr_o(sh_dr_o), .upd_dr_o(upd_dr_o),
    .cap_ir_o(cap_ir_o), .sh_ir_o(sh_ir_o), .upd_ir_o(upd_ir_o),
    .tdo_en_o(tdo_en_o)
  );

  function automatic int model(input int s, input logic t);
    case (s)
      0:  return t ? 0 : 1;
      1:  return t ? 2 : 1;
      2:  return t ? 9 : 3;
      9:  return t ? 0 : 10;
      3, 4:   return t ? 5 : 4;
      10, 11: return t ? 12 : 11;
      5:  return t ? 8 : 6;
      12: return t ? 15 : 13;
      6:  return t ? 7 : 6;
      13: return t ? 14 : 13;
      7:  return t ? 8 : 4;
      14: return t ? 15 : 11;
      default: return t ? 2 : 1;
    endcase
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_comb(input int s);
    chk("R2 state", int'(state_o), s);
    chk("R8 test_reset", int'(test_reset_o), int'(s == 0));
    chk("R7 ir_sel", int'(ir_sel_o), int'(s >= 9));
    chk("R4 cap_dr", int'(cap_dr_o), int'(s == 3));
    chk("R4 sh_dr", int'(sh_dr_o), int'(s == 4));
    chk("R4 cap_ir", int'(cap_ir_o), int'(s == 10));
    chk("R4 sh_ir", int'(sh_ir_o), int'(s == 11));
  endtask

  task automatic chk_fall(input int s);
    chk("R5 upd_dr", int'(upd_dr_o), int'(s == 8));
    chk("R5 upd_ir", int'(upd_ir_o), int'(s == 15));
    chk("R6 tdo_en", int'(tdo_en_o), int'(s == 4 || s == 11));
  endtask

  // called just after a falling edge; ends just after the next one
  task automatic step(input logic t);
    int prv;
    prv = ms;
    tms = t;
    ms = model(prv, t);
    cov[prv * 2 + int'(t)] = 1'b1;
    @(posedge tck); #2;
    chk_comb(ms);
    chk_fall(prv);
    @(negedge tck); #2;
    chk_fall(ms);
  endtask

  task automatic hard_reset();
    trst_n = 1'b0;
    #1;
    chk("R1 async state", int'(state_o), 0);
    chk("R1 async tdo_en", int'(tdo_en_o), 0);
    chk("R1 async upd", int'({upd_dr_o, upd_ir_o}), 0);
    @(negedge tck); #2;
    trst_n = 1'b1;
    ms = 0;
  endtask

  initial begin
    #2000000;
    nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nchk + 1 - nfail, nchk + 1);
    $finish;
  end

  initial begin
    @(negedge tck); #2;
    chk_comb(0);
    chk_fall(0);
    @(negedge tck); #2;
    trst_n = 1'b1;
    ms = 0;

    // R9 directed: data shift, pause, resume
    step(0); step(1); step(0); step(0);
    step(1); step(0); step(0); step(0);
    chk("R9 pause hold", int'(state_o), 6);
    chk("R9 no shift in pause", int'(sh_dr_o), 0);
    step(1); step(0);
    chk("R9 resume shift", int'(state_o), 4);
    // R1 asynchronous reset while shifting
    chk("R6 tdo_en before reset", int'(tdo_en_o), 1);
    hard_reset();

    // R9 instruction branch pause
    step(0); step(1); step(1); step(0); step(0);
    step(1); step(0); step(0);
    chk("R9 ir pause hold", int'(state_o), 13);
    step(1); step(0);
    chk("R9 ir resume shift", int'(state_o), 11);

    // R2 pseudo-random walk over the whole graph
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0]);
    end
    chk("R2 transition coverage", $countones(cov), 32);

    // R3 five ones from assorted states
    for (int tr = 0; tr < 40; tr++) begin
      for (int j = 0; j < (tr % 9) + 1; j++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        step(lfsr[3]);
      end
      for (int j = 0; j < 5; j++) step(1);
      chk("R3 five ones", int'(state_o), 0);
    end

    hard_reset();
    chk_comb(0);

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule